// File: doc/BRIEF.md
# Register-Mapped Mu-Law Compander

This peripheral converts audio samples between 16-bit linear two's-complement form and 8-bit mu-law codes. The conversion happens in place inside a pair of 8-bit data registers. Software reaches the block over a simple byte-wide register bus that has an address, a write strobe, write data, a read strobe and read data. A configuration register selects the mode, and a plain register write starts a conversion.

In squeeze (compress) mode, software first writes the low byte of a linear sample and then the high byte. Writing the high byte starts the conversion. One cycle later the high data register holds the mu-law code. In stretch (expand) mode, writing a code to the high data register starts the conversion. One cycle later the high and low registers together hold the decoded linear sample.

A conversion runs only while the serial-link enable bit is clear and exactly one of the two mode flags is set. In every other case the data registers behave as ordinary storage.

The sequencer has three states:
- `ST_IDLE` moves to `ST_SQUEEZE` on a compress start, or to `ST_STRETCH` on an expand start.
- `ST_SQUEEZE` always returns to `ST_IDLE` after one cycle and writes the code into the high register.
- `ST_STRETCH` always returns to `ST_IDLE` after one cycle and writes the linear result into both data registers.

Top module: `mulaw_compander`

## Requirements
- R1: After reset, the configuration register reads 0x30 and both data registers read 0x00. In 0x30, bit 5 (16-bit words) and bit 4 (stereo) are set, and the enable bit and both mode flags are clear.
- R2: The address map is 0 = configuration, 1 = low data, 2 = high data; address 3 reads 0x00. In the configuration register, bits 0, 1, 2, 4 and 5 are writable and bits 7, 6 and 3 read 0 when idle. The read data is 0x00 while the read strobe is low.
- R3: Compress mode needs configuration bit 0 (enable) = 0, bit 1 (compress flag) = 1 and bit 2 (expand flag) = 0. In this mode only a write to the high data register starts a conversion. A write to the low data register only stores the byte.
- R4: One cycle after a compress start, the high register holds the mu-law code of the sample {high, low}, and the low register keeps its value. The code is computed as follows:
  - x = sample >>> 2.
  - The magnitude |x| is clipped to 8158, and 33 is added.
  - The segment is the position of the leading one minus 5.
  - The mantissa is the four bits below the leading one.
  - The code is ~{sign, segment[2:0], mantissa[3:0]}, where sign is 1 for a negative sample.
- R5: Expand mode needs enable = 0, expand flag = 1 and compress flag = 0. A write to the high register starts a conversion. One cycle later {high, low} holds the decoded value, computed as follows:
  - c = ~code.
  - t = ((c[3:0] << 3) + 132) << c[6:4].
  - The result is t - 132, negated when c[7] = 1.
- R6: Configuration bit 3 (busy) reads 1 only during the single cycle after a start. A read of the high register in that cycle returns the raw byte that was written.
- R7: When both mode flags are set, or the enable bit is 1, a data write stores the raw byte, busy stays 0 and no conversion happens.
- R8: Writes to either data register during the busy cycle are ignored and start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, 0 when bus_rd is low |

## Verification
The assertions assume the following about the bus:
- At most one register operation occurs per cycle.
- The address and write data are known whenever a strobe is high.
- A configuration change never shares a cycle with a data write.

The stimulus keeps to these rules by changing every bus signal together on the falling edge and never raising read and write at once. The stimulus also includes writes placed deliberately in the busy cycle. This confirms that they neither corrupt the result nor restart the sequencer.

// File: rtl/mulaw_pkg.sv
package mulaw_pkg;
    localparam int LIN_W  = 16;
    localparam int CODE_W = 8;
    localparam int SEG_N  = 8;
    localparam int SEG_W  = $clog2(SEG_N);
    localparam int MAN_W  = 4;
    localparam int CLIP   = 8158;
    localparam int ENC_BIAS = 33;
    localparam int DEC_BIAS = 132;

    localparam int CFG_OFS = 0;
    localparam int LO_OFS  = 1;
    localparam int HI_OFS  = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SQUEEZE,
        ST_STRETCH
    } cnv_state_t;
endpackage

// File: rtl/mulaw_encoder.sv
module mulaw_encoder
    import mulaw_pkg::*;
(
    input  logic [LIN_W-1:0]  lin,
    output logic [CODE_W-1:0] code
);
    localparam int MAG_W = SEG_N + 5;

    logic [LIN_W-1:0] scaled;
    logic [LIN_W-1:0] mag;
    logic [MAG_W-1:0] clipped;
    logic [MAG_W-1:0] biased;
    logic [MAG_W-1:0] shifted;
    logic [SEG_W-1:0] seg;

    always_comb begin
        scaled  = LIN_W'($signed(lin) >>> 2);
        mag     = lin[LIN_W-1] ? (LIN_W'(0) - scaled) : scaled;
        clipped = (mag > LIN_W'(CLIP)) ? MAG_W'(CLIP) : mag[MAG_W-1:0];
        biased  = clipped + MAG_W'(ENC_BIAS);
        seg     = '0;
        for (int i = 0; i < SEG_N; i++) begin
            if (biased[i+5]) seg = SEG_W'(i);
        end
        shifted = biased >> (seg + 4'd1);
        code    = ~{lin[LIN_W-1], seg, shifted[MAN_W-1:0]};
    end
endmodule

// File: rtl/mulaw_decoder.sv
module mulaw_decoder
    import mulaw_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [LIN_W-1:0]  lin
);
    logic [CODE_W-1:0] c;
    logic [LIN_W-1:0]  step;
    logic [LIN_W-1:0]  mag;

    always_comb begin
        c    = ~code;
        step = (LIN_W'({c[MAN_W-1:0], 3'b000}) + LIN_W'(DEC_BIAS)) << c[6:4];
        mag  = step - LIN_W'(DEC_BIAS);
        lin  = c[CODE_W-1] ? (LIN_W'(0) - mag) : mag;
    end
endmodule

// File: rtl/mulaw_seq.sv
module mulaw_seq
    import mulaw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_sq,
    input  logic       start_st,
    output cnv_state_t state,
    output logic       busy
);
    cnv_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start_sq)      nxt = ST_SQUEEZE;
                else if (start_st) nxt = ST_STRETCH;
            end
            ST_SQUEEZE: nxt = ST_IDLE;
            ST_STRETCH: nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb busy = (state != ST_IDLE);

    // R6
    busy_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
    // R3
    squeeze_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_sq |=> (state == ST_SQUEEZE));
    // R5
    stretch_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_st |=> (state == ST_STRETCH));
endmodule

// File: rtl/mulaw_compander.sv
module mulaw_compander
    import mulaw_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata
);
    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(CFG_OFS);
    localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(LO_OFS);
    localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(HI_OFS);

    logic       en_q, sq_q, st_q, stereo_q, wide_q;
    logic [7:0] lo_q, hi_q;
    logic       sq_sel, st_sel, hi_wr, lo_wr, start_sq, start_st, busy;
    logic [CODE_W-1:0] enc_code;
    logic [LIN_W-1:0]  dec_lin;
    cnv_state_t        state;

    always_comb begin
        sq_sel   = !en_q && sq_q && !st_q;
        st_sel   = !en_q && st_q && !sq_q;
        hi_wr    = bus_wr && (bus_addr == A_HI) && !busy;
        lo_wr    = bus_wr && (bus_addr == A_LO) && !busy;
        start_sq = hi_wr && sq_sel;
        start_st = hi_wr && st_sel;
    end

    mulaw_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_sq (start_sq),
        .start_st (start_st),
        .state    (state),
        .busy     (busy)
    );

    mulaw_encoder u_enc (
        .lin  ({hi_q, lo_q}),
        .code (enc_code)
    );

    mulaw_decoder u_dec (
        .code (hi_q),
        .lin  (dec_lin)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            sq_q     <= 1'b0;
            st_q     <= 1'b0;
            stereo_q <= 1'b1;
            wide_q   <= 1'b1;
        end else if (bus_wr && (bus_addr == A_CFG)) begin
            en_q     <= bus_wdata[0];
            sq_q     <= bus_wdata[1];
            st_q     <= bus_wdata[2];
            stereo_q <= bus_wdata[4];
            wide_q   <= bus_wdata[5];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (lo_wr) lo_q <= bus_wdata;
                    if (hi_wr) hi_q <= bus_wdata;
                end
                ST_SQUEEZE: hi_q <= enc_code;
                ST_STRETCH: {hi_q, lo_q} <= dec_lin;
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == A_CFG)
                bus_rdata = {2'b00, wide_q, stereo_q, busy, st_q, sq_q, en_q};
            else if (bus_addr == A_LO)
                bus_rdata = lo_q;
            else if (bus_addr == A_HI)
                bus_rdata = hi_q;
        end
    end

    // R7
    raw_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_wr && !sq_sel && !st_sel) |=> (!busy && hi_q == $past(bus_wdata)));
    // R6
    raw_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_sq || start_st) |=> (busy && hi_q == $past(bus_wdata)));
    // R4
    low_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SQUEEZE) |=> (lo_q == $past(lo_q)));
    // R8
    busy_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && bus_addr == A_HI) |=> !busy);
endmodule

// File: tb/sim_mulaw_compander.sv
module sim_mulaw_compander;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } sb_item_t;
    sb_item_t sb[$];

    always #5 clk = ~clk;

    mulaw_compander #(.ADDR_W(2)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] ref_enc(input logic [15:0] s);
        int x, m, seg, mant, neg;
        x   = int'($signed(s)) >>> 2;
        neg = (x < 0) ? 1 : 0;
        m   = neg ? -x : x;
        if (m > 8158) m = 8158;
        m   = m + 33;
        seg = 0;
        while (m >= (64 << seg)) seg++;
        mant = (m >> (seg + 1)) & 15;
        return ~8'((neg << 7) | (seg << 4) | mant);
    endfunction

    function automatic logic [15:0] ref_dec(input logic [7:0] code);
        int c, t, v;
        c = int'(~code) & 255;
        t = (((c & 15) << 3) + 132) << ((c >> 4) & 7);
        v = ((c & 128) != 0) ? (132 - t) : (t - 132);
        return 16'(v);
    endfunction

    task automatic bus_op(input bit w, input bit r, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_op(1'b1, 1'b0, a, d);
    endtask

    task automatic rd_expect(input logic [1:0] a, input logic [7:0] v, input string tag);
        sb_item_t it;
        it.val = v; it.tag = tag;
        sb.push_back(it);
        bus_op(1'b0, 1'b1, a, 8'h00);
    endtask

    // monitor: pops one expected item for every read cycle
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (bus_rd) begin
                sb_item_t it;
                n_tests++;
                if (sb.size() == 0) begin
                    n_fail++;
                    $display("FAIL scoreboard: read with no expected item");
                end else begin
                    it = sb.pop_front();
                    if (bus_rdata !== it.val) begin
                        n_fail++;
                        $display("FAIL %s: got 0x%02h expected 0x%02h", it.tag, bus_rdata, it.val);
                    end
                end
            end
        end
    end

    task automatic squeeze(input logic [15:0] s, input bit peek_cfg);
        wr(2'd1, s[7:0]);
        wr(2'd2, s[15:8]);
        if (peek_cfg) rd_expect(2'd0, 8'h3A, "R6 busy bit");
        else          rd_expect(2'd2, s[15:8], "R6 raw high during busy");
        rd_expect(2'd2, ref_enc(s), "R4 code");
        rd_expect(2'd1, s[7:0], "R4 low kept");
    endtask

    task automatic stretch(input logic [7:0] c);
        logic [15:0] e;
        e = ref_dec(c);
        wr(2'd2, c);
        rd_expect(2'd2, c, "R6 raw code during busy");
        rd_expect(2'd2, e[15:8], "R5 high");
        rd_expect(2'd1, e[7:0], "R5 low");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1
        rd_expect(2'd0, 8'h30, "R1 cfg reset");
        rd_expect(2'd1, 8'h00, "R1 low reset");
        rd_expect(2'd2, 8'h00, "R1 high reset");
        // R2
        rd_expect(2'd3, 8'h00, "R2 unmapped");
        bus_op(1'b0, 1'b0, 2'd0, 8'h00);
        #3;
        n_tests++;
        if (bus_rdata !== 8'h00) begin
            n_fail++;
            $display("FAIL R2 idle rdata: got 0x%02h expected 0x00", bus_rdata);
        end
        // R3
        wr(2'd0, 8'h32);
        wr(2'd1, 8'h5C);
        rd_expect(2'd0, 8'h32, "R3 low write no start");
        squeeze(16'h0000, 1'b1);
        squeeze(16'd1000, 1'b0);
        squeeze(-16'sd1000, 1'b0);
        squeeze(16'h7FFF, 1'b0);
        squeeze(16'h8000, 1'b0);
        squeeze(16'hFFFC, 1'b0);
        squeeze(16'h0123, 1'b0);
        // R8
        wr(2'd1, 8'h34);
        wr(2'd2, 8'h12);
        wr(2'd1, 8'hEE);
        rd_expect(2'd2, ref_enc(16'h1234), "R8 code after dropped write");
        rd_expect(2'd1, 8'h34, "R8 low after dropped write");
        wr(2'd2, 8'h56);
        wr(2'd2, 8'h99);
        rd_expect(2'd0, 8'h32, "R8 no restart");
        // R5
        wr(2'd0, 8'h34);
        stretch(8'hFF);
        stretch(8'h00);
        stretch(8'h80);
        stretch(8'h7F);
        stretch(8'h5A);
        stretch(8'hA5);
        stretch(8'h13);
        // R7
        wr(2'd0, 8'h36);
        wr(2'd1, 8'h44);
        wr(2'd2, 8'h12);
        rd_expect(2'd0, 8'h36, "R7 both flags no busy");
        rd_expect(2'd2, 8'h12, "R7 both flags raw high");
        rd_expect(2'd1, 8'h44, "R7 both flags raw low");
        wr(2'd0, 8'h33);
        wr(2'd2, 8'hC3);
        rd_expect(2'd0, 8'h33, "R7 enabled no busy");
        rd_expect(2'd2, 8'hC3, "R7 enabled raw high");
        wr(2'd0, 8'h35);
        wr(2'd2, 8'h0F);
        rd_expect(2'd2, 8'h0F, "R7 enabled expand raw");
        // R2
        wr(2'd0, 8'hFF);
        rd_expect(2'd0, 8'h37, "R2 cfg writable bits");
        wr(2'd0, 8'h00);
        rd_expect(2'd0, 8'h00, "R2 cfg cleared");
        bus_op(1'b0, 1'b0, 2'd0, 8'h00);
        bus_op(1'b0, 1'b0, 2'd0, 8'h00);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule